// File: doc/BRIEF.md
# Sound Chip Register Bus Interface

This block is the host-facing register front end of a programmable sound generator. It holds sixteen byte-wide registers behind two ports: a select port that holds the register number and a data port that reads or writes the selected register. A small bus picks the port. Address bit 1 chooses between the two ports. Address bit 0 picks a byte lane, so the odd lanes alias the two ports. A flag marks byte-size accesses, and a strobe with a write flag marks each access.

The block masks the unused bits of some registers on writes. It keeps a read-back latch that follows the select and data traffic. For every access it accepts, it raises a one-cycle wait request. Writes to the sound registers (indices 0 to 13) go out to the tone-rendering logic as an index-plus-data strobe. All sixteen registers are also exported as one flat bus.

A one-hot-free state machine tracks the access being served. Its states are:
- ST_IDLE: no access.
- ST_SEL_WR: select written.
- ST_DAT_WR: data stored.
- ST_DAT_DROP: data write with an out-of-range select.
- ST_REG_RD: read at the select port.
- ST_VOID_RD: read at any other address.

Each cycle the state machine moves from any state to the state that the decoded access names. With no strobe, or with an ignored shadow write, it moves to ST_IDLE. Every output is driven from the state during the cycle that follows the sampled access.

Top module: `sreg_bus_if`

## Requirements
- R1: After reset all registers read 0x00 except register 14, which reads 0xFF. The select value is 0, and wait_req and snd_we are low.
- R2: With bus_a1=0, a write loads all 8 bits of the select register. With bus_a1=1, a write goes to the selected register. bus_a0=1 aliases the same port when bus_byte=1.
- R3: A write with bus_a0=1 and bus_byte=0 is ignored. It changes no register, produces no snd_we, and raises no wait_req.
- R4: When the select value is 16 or more, data writes change no register and produce no snd_we. Reads at the select port then return 0xFF.
- R5: A data write to register 1, 3, 5 or 13 stores only bits 3:0. A data write to register 6, 8, 9 or 10 stores only bits 4:0. Other registers store all 8 bits.
- R6: A read at the select port returns the unmasked byte of the last data write until the select register is written again. After a select write, such a read returns the stored (masked) contents of the newly selected register.
- R7: Reads with bus_a1=1 or bus_a0=1 return 0xFF.
- R8: Every accepted access raises wait_req for exactly the cycle after its strobe. Accepted accesses are all reads, all even-lane writes, and odd-lane writes with bus_byte=1. Data writes dropped under R4 still count as accepted.
- R9: A stored data write to register 0..13 pulses snd_we in the cycle after the strobe, with snd_idx set to the register number and snd_data set to the masked byte. Registers 14 and 15 never pulse it.
- R10: Register i is visible on regs_flat[8i+7:8i] from the cycle after its write. regs_flat does not change without a data write.
- R11: bus_rdata carries the read result in the cycle after a read strobe and is 0xFF in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_a1 | input | 1 | 0 = select port, 1 = data port |
| bus_a0 | input | 1 | Byte lane (1 = shadow lane) |
| bus_byte | input | 1 | Access is byte-sized |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, cycle after strobe |
| wait_req | output | 1 | One-cycle wait-state request |
| snd_we | output | 1 | Sound register write strobe |
| snd_idx | output | 4 | Sound register number |
| snd_data | output | 8 | Masked sound register data |
| regs_flat | output | 128 | All registers, register i at bits 8i+7:8i |

## Verification
Directed sequences come first. One writes register 3 with 0x10 and reads it back before and after reselecting it, which separates the unmasked latch from the masked storage. Another parks the select at 16 and 0xFF, which separates dropped from stored writes. Word-size shadow writes separate ignored accesses from the byte-size aliases. A seeded random mix of all lane, size and direction combinations then runs, with select values both in and out of range. Every cycle it compares the wait, the strobe, the read data and the full register image against a bench model.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_SEL_WR,
        K_DAT_WR,
        K_REG_RD,
        K_VOID_RD,
        K_IGNORED
    } acc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL_WR,
        ST_DAT_WR,
        ST_DAT_DROP,
        ST_REG_RD,
        ST_VOID_RD
    } bus_state_t;

    // Bits kept on a data write, by register number.
    function automatic logic [7:0] keep_mask(input int idx);
        case (idx)
            1, 3, 5, 13: keep_mask = 8'h0F;
            6, 8, 9, 10: keep_mask = 8'h1F;
            default:     keep_mask = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
    import sreg_pkg::*;
(
    input  logic      cs,
    input  logic      we,
    input  logic      a1,
    input  logic      a0,
    input  logic      byte_sz,
    output acc_kind_t kind
);
    always_comb begin
        if (!cs)
            kind = K_NONE;
        else if (!we)
            kind = (a1 || a0) ? K_VOID_RD : K_REG_RD;
        else if (a0 && !byte_sz)
            kind = K_IGNORED;
        else
            kind = a1 ? K_DAT_WR : K_SEL_WR;
    end
endmodule

// File: rtl/sreg_file.sv
module sreg_file #(
    parameter int NREGS  = 16,
    parameter int DW     = 8,
    parameter int HI_IDX = 14,
    localparam int IW    = $clog2(NREGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [DW-1:0]       wr_data,
    output logic [NREGS*DW-1:0] flat
);
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        localparam logic [DW-1:0] RST_V = (i == HI_IDX) ? {DW{1'b1}} : {DW{1'b0}};
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= RST_V;
            else if (wr_en && (wr_idx == IW'(i)))
                q <= wr_data;
        end
        assign flat[i*DW +: DW] = q;
    end
endmodule

// File: rtl/sreg_readback.sv
module sreg_readback #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_raw,
    input  logic [DW-1:0] raw,
    input  logic          load_stored,
    input  logic [DW-1:0] stored,
    output logic [DW-1:0] latch_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            latch_q <= '0;
        else if (load_raw)
            latch_q <= raw;
        else if (load_stored)
            latch_q <= stored;
    end
endmodule

// File: rtl/sreg_bus_if.sv
module sreg_bus_if
    import sreg_pkg::*;
#(
    parameter int NREGS  = 16,
    parameter int NSOUND = 14,
    parameter int DW     = 8,
    parameter int HI_IDX = 14,
    localparam int IW    = $clog2(NREGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_cs,
    input  logic                bus_we,
    input  logic                bus_a1,
    input  logic                bus_a0,
    input  logic                bus_byte,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    output logic                wait_req,
    output logic                snd_we,
    output logic [IW-1:0]       snd_idx,
    output logic [DW-1:0]       snd_data,
    output logic [NREGS*DW-1:0] regs_flat
);
    localparam logic [DW-1:0] NREGS_V  = DW'(NREGS);
    localparam logic [IW-1:0] NSOUND_V = IW'(NSOUND);

    acc_kind_t     kind;
    bus_state_t    state_q, state_d;
    logic [DW-1:0] sel_q;
    logic          sel_valid;
    logic [IW-1:0] sel_idx;
    logic          wr_en;
    logic [DW-1:0] wr_masked;
    logic [DW-1:0] latch_q;
    logic [DW-1:0] new_stored;
    logic          new_valid;
    logic [DW-1:0] rd_q;
    logic [IW-1:0] snd_idx_q;
    logic [DW-1:0] snd_data_q;

    sreg_decode u_dec (
        .cs      (bus_cs),
        .we      (bus_we),
        .a1      (bus_a1),
        .a0      (bus_a0),
        .byte_sz (bus_byte),
        .kind    (kind)
    );

    assign sel_valid = (sel_q < NREGS_V);
    assign sel_idx   = sel_q[IW-1:0];
    assign wr_en     = (kind == K_DAT_WR) && sel_valid;
    assign wr_masked = bus_wdata & keep_mask(int'(sel_idx));
    assign new_valid = (bus_wdata < NREGS_V);
    assign new_stored = new_valid ? regs_flat[bus_wdata[IW-1:0]*DW +: DW] : {DW{1'b1}};

    sreg_file #(
        .NREGS  (NREGS),
        .DW     (DW),
        .HI_IDX (HI_IDX)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (sel_idx),
        .wr_data (wr_masked),
        .flat    (regs_flat)
    );

    sreg_readback #(
        .DW (DW)
    ) u_rb (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_raw    (wr_en),
        .raw         (bus_wdata),
        .load_stored (kind == K_SEL_WR),
        .stored      (new_stored),
        .latch_q     (latch_q)
    );

    // Next state from the decoded access
    always_comb begin
        unique case (kind)
            K_SEL_WR:  state_d = ST_SEL_WR;
            K_DAT_WR:  state_d = sel_valid ? ST_DAT_WR : ST_DAT_DROP;
            K_REG_RD:  state_d = ST_REG_RD;
            K_VOID_RD: state_d = ST_VOID_RD;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and per-access captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sel_q      <= '0;
            rd_q       <= '1;
            snd_idx_q  <= '0;
            snd_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (kind == K_SEL_WR)
                sel_q <= bus_wdata;
            if (kind == K_REG_RD)
                rd_q <= sel_valid ? latch_q : {DW{1'b1}};
            if (wr_en) begin
                snd_idx_q  <= sel_idx;
                snd_data_q <= wr_masked;
            end
        end
    end

    // Outputs from the state
    always_comb begin
        wait_req  = 1'b0;
        snd_we    = 1'b0;
        bus_rdata = {DW{1'b1}};
        unique case (state_q)
            ST_IDLE:     wait_req = 1'b0;
            ST_SEL_WR:   wait_req = 1'b1;
            ST_DAT_DROP: wait_req = 1'b1;
            ST_VOID_RD:  wait_req = 1'b1;
            ST_DAT_WR: begin
                wait_req = 1'b1;
                snd_we   = (snd_idx_q < NSOUND_V);
            end
            ST_REG_RD: begin
                wait_req  = 1'b1;
                bus_rdata = rd_q;
            end
            default:     wait_req = 1'b0;
        endcase
    end

    assign snd_idx  = snd_idx_q;
    assign snd_data = snd_data_q;

endmodule

// File: rtl/sreg_bus_if_chk.sv
module sreg_bus_if_chk #(
    parameter int NREGS  = 16,
    parameter int NSOUND = 14,
    parameter int DW     = 8,
    localparam int IW    = $clog2(NREGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_cs,
    input logic                bus_we,
    input logic                bus_a1,
    input logic                bus_a0,
    input logic                bus_byte,
    input logic [DW-1:0]       bus_rdata,
    input logic                wait_req,
    input logic                snd_we,
    input logic [IW-1:0]       snd_idx,
    input logic [DW-1:0]       sel,
    input logic [NREGS*DW-1:0] regs_flat
);
    p_shadow_word_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_we && bus_a0 && !bus_byte) |=> (!wait_req && !snd_we));

    p_read_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we) |=> wait_req);

    p_no_strobe_high_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_we && bus_a1 && (!bus_a0 || bus_byte) && (sel >= DW'(NREGS))) |=> !snd_we);

    p_odd_read_ff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && !bus_we && (bus_a1 || bus_a0)) |=> (bus_rdata == {DW{1'b1}}));

    p_strobe_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snd_we |-> (wait_req && (snd_idx < IW'(NSOUND))));

    p_regs_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_we) |=> $stable(regs_flat));

    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs |=> (bus_rdata == {DW{1'b1}}));
endmodule

bind sreg_bus_if sreg_bus_if_chk #(
    .NREGS  (NREGS),
    .NSOUND (NSOUND),
    .DW     (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_cs    (bus_cs),
    .bus_we    (bus_we),
    .bus_a1    (bus_a1),
    .bus_a0    (bus_a0),
    .bus_byte  (bus_byte),
    .bus_rdata (bus_rdata),
    .wait_req  (wait_req),
    .snd_we    (snd_we),
    .snd_idx   (snd_idx),
    .sel       (sel_q),
    .regs_flat (regs_flat)
);

// File: tb/sim_sreg_bus_if.sv
module sim_sreg_bus_if;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_cs = 1'b0, bus_we = 1'b0, bus_a1 = 1'b0, bus_a0 = 1'b0, bus_byte = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic         wait_req, snd_we;
    logic [3:0]   snd_idx;
    logic [7:0]   snd_data;
    logic [127:0] regs_flat;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] m_regs [16];
    logic [7:0] m_sel, m_latch;

    always #5 clk = ~clk;

    sreg_bus_if u0 (.*);

    function automatic logic [7:0] mask_of(input int i);
        if (i == 1 || i == 3 || i == 5 || i == 13) return 8'h0F;
        if (i == 6 || i == 8 || i == 9 || i == 10) return 8'h1F;
        return 8'hFF;
    endfunction

    function automatic logic [127:0] model_flat();
        logic [127:0] f;
        for (int i = 0; i < 16; i++) f[i*8 +: 8] = m_regs[i];
        return f;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit we, input bit a1, input bit a0, input bit bsz, input logic [7:0] d);
        bit acc, exp_snd;
        logic [7:0] exp_rd, exp_sd;
        logic [3:0] exp_si;
        acc = !we || !a0 || bsz;
        exp_rd = 8'hFF; exp_snd = 0; exp_si = 0; exp_sd = 0;
        if (!we) begin
            if (!a1 && !a0) exp_rd = (m_sel < 16) ? m_latch : 8'hFF;
        end else if (acc) begin
            if (!a1) begin
                m_sel = d;
                m_latch = (d < 16) ? m_regs[d[3:0]] : 8'hFF;
            end else if (m_sel < 16) begin
                m_regs[m_sel[3:0]] = d & mask_of(int'(m_sel));
                m_latch = d;
                if (m_sel < 14) begin
                    exp_snd = 1; exp_si = m_sel[3:0]; exp_sd = d & mask_of(int'(m_sel));
                end
            end
        end
        @(negedge clk);
        bus_cs = 1; bus_we = we; bus_a1 = a1; bus_a0 = a0; bus_byte = bsz; bus_wdata = d;
        @(posedge clk); #1;
        chk(acc ? "R8 wait" : "R3 wait", 128'(wait_req), 128'(acc));
        chk("R9 snd_we", 128'(snd_we), 128'(exp_snd));
        if (exp_snd) begin
            chk("R9 snd_idx", 128'(snd_idx), 128'(exp_si));
            chk("R9/R5 snd_data", 128'(snd_data), 128'(exp_sd));
        end
        if (!we) chk((a1 || a0) ? "R7 rdata" : "R6/R4/R11 rdata", 128'(bus_rdata), 128'(exp_rd));
        chk("R10/R5/R2 regs", regs_flat, model_flat());
        @(negedge clk); bus_cs = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) m_regs[i] = (i == 14) ? 8'hFF : 8'h00;
        m_sel = 0; m_latch = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 regs", regs_flat, model_flat());
        chk("R1 wait", 128'(wait_req), 128'(0));
        chk("R1 snd_we", 128'(snd_we), 128'(0));
        chk("R11 idle rdata", 128'(bus_rdata), 128'(8'hFF));
        access(0, 0, 0, 1, 0);          // R1 select 0 read: latch 0
        // R6 unmasked read-back then masked after reselect
        access(1, 0, 0, 1, 8'd3);
        access(1, 1, 0, 1, 8'h10);
        access(0, 0, 0, 1, 0);
        access(1, 0, 0, 0, 8'd3);
        access(0, 0, 0, 1, 0);
        // R5 masks on every register
        for (int r = 0; r < 16; r++) begin
            access(1, 0, 1, 1, 8'(r));  // R2 shadow byte select
            access(1, 1, 1, 1, 8'hFF);  // R2 shadow byte data
        end
        // R3 word-size shadow writes ignored
        access(1, 0, 0, 1, 8'd2);
        access(1, 1, 1, 0, 8'hAA);
        access(1, 0, 1, 0, 8'd7);
        access(0, 0, 0, 0, 0);
        // R4 out-of-range select
        access(1, 0, 0, 1, 8'd16);
        access(1, 1, 0, 1, 8'h55);
        access(0, 0, 0, 1, 0);
        access(1, 0, 0, 1, 8'hFF);
        access(1, 1, 0, 0, 8'h66);
        access(0, 0, 0, 1, 0);
        // R7 reads at other addresses
        access(1, 0, 0, 1, 8'd14);
        access(0, 1, 0, 1, 0);
        access(0, 0, 1, 1, 0);
        access(0, 1, 1, 0, 0);
        // Random mix
        for (int k = 0; k < 1500; k++) begin
            v = ($urandom % 10 < 8) ? 8'($urandom % 16) : 8'($urandom);
            access(1'($urandom), 1'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 != 0),
                   ($urandom % 2) ? v : 8'($urandom));
            if ($urandom % 8 == 0) begin
                @(posedge clk); #1;
                chk("R11 idle rdata", 128'(bus_rdata), 128'(8'hFF));
                chk("R8 idle wait", 128'(wait_req), 128'(0));
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule